// File: doc/BRIEF.md
# Mode-selectable 4-bit ALU slice

This block is a purely combinational arithmetic and logic slice. Two 4-bit operands, a 4-bit function code and a mode bit pick one of 32 operations. With the mode bit low the slice does arithmetic: it forms two operand terms from A and B, adds them together with the carry input, and settles every internal carry through look-ahead logic instead of rippling. With the mode bit high it applies one of sixteen bitwise functions of A and B.

Besides the 4-bit result, the slice drives a carry output and a group propagate/group generate pair. An external look-ahead unit can use this pair to join several slices into a wider word. To form a wider ALU, place several copies side by side and feed the same code and mode to all of them.

Top module: `alu_slice`

## Requirements
- R1: With `logic_mode`=0 and `carry_in`=0, codes give: 0000 A, 0001 A OR B, 0011 all ones (minus one), 0110 A minus B minus 1, 1001 A plus B, 1111 A. All results are modulo 16.
- R2: With `logic_mode`=0, each code picks two terms X and Y, and the result is X+Y+`carry_in` modulo 16. The pairs (X,Y) are: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (1111,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A,~B), 0111 (A&~B,1111), 1000 (A,A&B), 1001 (A,B), 1010 (A|~B,A&B), 1011 (A&B,1111), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (A,0).
- R3: With `logic_mode`=0, `carry_in`=1 adds one to the result modulo 16. For example, code 0110 then gives A minus B.
- R4: With `logic_mode`=0, `carry_out` equals bit 4 of the 5-bit sum X+Y+`carry_in`.
- R5: With `logic_mode`=1, codes give: 0000 NOT A, 0001 NOT(A OR B), 0011 0000, 0110 A XOR B, 1001 NOT(A XOR B), 1111 1111.
- R6: With `logic_mode`=1, the other codes give: 0010 ~A&B, 0100 NOT(A AND B), 0101 NOT B, 0111 A&~B, 1000 ~A|B, 1010 B, 1011 A&B, 1100 A|~B, 1101 A|B, 1110 A.
- R7: With `logic_mode`=1, `carry_in` has no effect on `result`, and `carry_out`, `grp_prop` and `grp_gen` are all 0.
- R8: With `logic_mode`=0, `grp_prop` is 1 exactly when X XOR Y is 1111, and `grp_gen` is 1 exactly when X+Y without carry-in exceeds 15.
- R9: With `logic_mode`=0, `carry_out` equals `grp_gen` OR (`grp_prop` AND `carry_in`). This lets an external look-ahead unit predict the carry out of the slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| fn_sel | input | 4 | Function code |
| logic_mode | input | 1 | 0 = arithmetic table, 1 = bitwise table |
| carry_in | input | 1 | Carry into bit 0 (arithmetic only) |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Carry out of bit 3 |
| grp_prop | output | 1 | Group propagate |
| grp_gen | output | 1 | Group generate |

## Verification
The hardest case to reach is a carry that travels the full width of the slice. This needs every bit to propagate (X XOR Y all ones, so `grp_prop`=1) while the carry input is 1. Only a few operand pairs meet this under each code, for instance B = NOT A under plain addition. The stimulus therefore sweeps every combination of mode, code, A, B and carry input. Each full-width propagate case is then certain to occur and is compared against an independent model.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        AR_PASS_A    = 4'b0000,
        AR_OR        = 4'b0001,
        AR_ORN       = 4'b0010,
        AR_ONES      = 4'b0011,
        AR_A_ANDN    = 4'b0100,
        AR_OR_ANDN   = 4'b0101,
        AR_SUB_M1    = 4'b0110,
        AR_ANDN_M1   = 4'b0111,
        AR_A_AND     = 4'b1000,
        AR_ADD       = 4'b1001,
        AR_ORN_AND   = 4'b1010,
        AR_AND_M1    = 4'b1011,
        AR_DOUBLE    = 4'b1100,
        AR_OR_A      = 4'b1101,
        AR_ORN_A     = 4'b1110,
        AR_PASS_A2   = 4'b1111
    } arith_op_e;

    typedef enum logic [SEL_W-1:0] {
        LG_NOT_A  = 4'b0000,
        LG_NOR    = 4'b0001,
        LG_NA_B   = 4'b0010,
        LG_ZERO   = 4'b0011,
        LG_NAND   = 4'b0100,
        LG_NOT_B  = 4'b0101,
        LG_XOR    = 4'b0110,
        LG_A_NB   = 4'b0111,
        LG_NA_OR  = 4'b1000,
        LG_XNOR   = 4'b1001,
        LG_PASS_B = 4'b1010,
        LG_AND    = 4'b1011,
        LG_A_ORNB = 4'b1100,
        LG_OR     = 4'b1101,
        LG_PASS_A = 4'b1110,
        LG_ONES   = 4'b1111
    } logic_op_e;

    typedef struct packed {
        logic cout;
        logic prop;
        logic gen;
    } grp_t;

endpackage

// File: rtl/alu_opgen.sv
module alu_opgen
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [SEL_W-1:0] sel,
    output logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y
);
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ZERO = '0;

    always_comb begin
        x = a;
        y = ZERO;
        case (arith_op_e'(sel))
            AR_PASS_A:  begin x = a;       y = ZERO;   end
            AR_OR:      begin x = a | b;   y = ZERO;   end
            AR_ORN:     begin x = a | ~b;  y = ZERO;   end
            AR_ONES:    begin x = ONES;    y = ZERO;   end
            AR_A_ANDN:  begin x = a;       y = a & ~b; end
            AR_OR_ANDN: begin x = a | b;   y = a & ~b; end
            AR_SUB_M1:  begin x = a;       y = ~b;     end
            AR_ANDN_M1: begin x = a & ~b;  y = ONES;   end
            AR_A_AND:   begin x = a;       y = a & b;  end
            AR_ADD:     begin x = a;       y = b;      end
            AR_ORN_AND: begin x = a | ~b;  y = a & b;  end
            AR_AND_M1:  begin x = a & b;   y = ONES;   end
            AR_DOUBLE:  begin x = a;       y = a;      end
            AR_OR_A:    begin x = a | b;   y = a;      end
            AR_ORN_A:   begin x = a | ~b;  y = a;      end
            AR_PASS_A2: begin x = a;       y = ZERO;   end
            default:    begin x = a;       y = ZERO;   end
        endcase
    end

    // R2: add and subtract forms keep their operand terms
    always_comb begin
        if (sel == AR_ADD) begin
            a_r2_add_terms: assert (x == a && y == b)
                else $error("a_r2_add_terms");
        end
        if (sel == AR_SUB_M1) begin
            a_r2_sub_terms: assert ((x ^ y ^ ~b) == a)
                else $error("a_r2_sub_terms");
        end
    end
endmodule

// File: rtl/alu_cla.sv
module alu_cla
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output grp_t             grp
);
    logic [WIDTH-1:0] p;
    logic [WIDTH-1:0] g;
    logic [WIDTH:0]   c;
    logic             gg;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign p[i]   = x[i] ^ y[i];
        assign g[i]   = x[i] & y[i];
        assign sum[i] = p[i] ^ c[i];
    end

    // every carry expanded as a flat sum of products of p, g and cin
    always_comb begin
        logic acc;
        logic chain;
        c[0] = cin;
        for (int i = 1; i <= WIDTH; i++) begin
            acc = 1'b0;
            for (int j = 0; j < i; j++) begin
                chain = g[j];
                for (int k = j + 1; k < i; k++) chain = chain & p[k];
                acc = acc | chain;
            end
            chain = cin;
            for (int k = 0; k < i; k++) chain = chain & p[k];
            c[i] = acc | chain;
        end
    end

    // group generate: carry out of the top bit with no carry in
    always_comb begin
        logic chain;
        gg = 1'b0;
        for (int j = 0; j < WIDTH; j++) begin
            chain = g[j];
            for (int k = j + 1; k < WIDTH; k++) chain = chain & p[k];
            gg = gg | chain;
        end
    end

    assign grp.cout = c[WIDTH];
    assign grp.prop = &p;
    assign grp.gen  = gg;

    always_comb begin
        logic [WIDTH:0] wide;
        wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        a_r4_sum_matches: assert ({grp.cout, sum} == wide)
            else $error("a_r4_sum_matches");
        a_r9_cout_group: assert (grp.cout == (grp.gen | (grp.prop & cin)))
            else $error("a_r9_cout_group");
        a_r8_prop_gen_excl: assert (!(grp.prop && grp.gen))
            else $error("a_r8_prop_gen_excl");
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [SEL_W-1:0] sel,
    output logic [WIDTH-1:0] f
);
    always_comb begin
        case (logic_op_e'(sel))
            LG_NOT_A:  f = ~a;
            LG_NOR:    f = ~(a | b);
            LG_NA_B:   f = ~a & b;
            LG_ZERO:   f = '0;
            LG_NAND:   f = ~(a & b);
            LG_NOT_B:  f = ~b;
            LG_XOR:    f = a ^ b;
            LG_A_NB:   f = a & ~b;
            LG_NA_OR:  f = ~a | b;
            LG_XNOR:   f = ~(a ^ b);
            LG_PASS_B: f = b;
            LG_AND:    f = a & b;
            LG_A_ORNB: f = a | ~b;
            LG_OR:     f = a | b;
            LG_PASS_A: f = a;
            LG_ONES:   f = '1;
            default:   f = '0;
        endcase
    end

    // R5: complementary pair of codes produce complementary outputs
    always_comb begin
        if (sel == LG_XNOR) begin
            a_r5_xnor_vs_xor: assert ((f ^ a ^ b) == '1)
                else $error("a_r5_xnor_vs_xor");
        end
    end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [SEL_W-1:0] fn_sel,
    input  logic             logic_mode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             grp_prop,
    output logic             grp_gen
);
    logic [WIDTH-1:0] term_x;
    logic [WIDTH-1:0] term_y;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    grp_t             grp;

    alu_opgen #(.WIDTH(WIDTH)) u_opgen (
        .a   (op_a),
        .b   (op_b),
        .sel (fn_sel),
        .x   (term_x),
        .y   (term_y)
    );

    alu_cla #(.WIDTH(WIDTH)) u_cla (
        .x   (term_x),
        .y   (term_y),
        .cin (carry_in),
        .sum (arith_res),
        .grp (grp)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (fn_sel),
        .f   (logic_res)
    );

    always_comb begin
        if (logic_mode) begin
            result    = logic_res;
            carry_out = 1'b0;
            grp_prop  = 1'b0;
            grp_gen   = 1'b0;
        end else begin
            result    = arith_res;
            carry_out = grp.cout;
            grp_prop  = grp.prop;
            grp_gen   = grp.gen;
        end
    end

    always_comb begin
        if (logic_mode) begin
            a_r7_quiet_carry: assert (!carry_out && !grp_prop && !grp_gen)
                else $error("a_r7_quiet_carry");
        end else begin
            a_r1_pass_a: assert (fn_sel != AR_PASS_A || carry_in || result == op_a)
                else $error("a_r1_pass_a");
        end
    end
endmodule

// File: tb/alu_slice_tb.sv
module alu_slice_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [3:0] fn_sel = '0;
    logic       logic_mode = 1'b0;
    logic       carry_in = 1'b0;
    logic [3:0] result;
    logic       carry_out;
    logic       grp_prop;
    logic       grp_gen;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] a, b, sel;
        logic       mode, cin;
        logic [3:0] res;
        logic       co, gp, gg;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    alu_slice u_dut (
        .op_a       (op_a),
        .op_b       (op_b),
        .fn_sel     (fn_sel),
        .logic_mode (logic_mode),
        .carry_in   (carry_in),
        .result     (result),
        .carry_out  (carry_out),
        .grp_prop   (grp_prop),
        .grp_gen    (grp_gen)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit stated_code(input logic [3:0] s);
        return (s == 4'd0 || s == 4'd1 || s == 4'd3 || s == 4'd6 ||
                s == 4'd9 || s == 4'd15);
    endfunction

    function automatic item_t model(input logic mode, input logic [3:0] s,
                                    input logic [3:0] a, input logic [3:0] b,
                                    input logic cin);
        item_t it;
        logic [3:0] x, y;
        logic [4:0] tot;
        it.a = a; it.b = b; it.sel = s; it.mode = mode; it.cin = cin;
        if (!mode) begin
            case (s)
                4'd0:  begin x = a;      y = 4'h0;   end
                4'd1:  begin x = a | b;  y = 4'h0;   end
                4'd2:  begin x = a | ~b; y = 4'h0;   end
                4'd3:  begin x = 4'hF;   y = 4'h0;   end
                4'd4:  begin x = a;      y = a & ~b; end
                4'd5:  begin x = a | b;  y = a & ~b; end
                4'd6:  begin x = a;      y = ~b;     end
                4'd7:  begin x = a & ~b; y = 4'hF;   end
                4'd8:  begin x = a;      y = a & b;  end
                4'd9:  begin x = a;      y = b;      end
                4'd10: begin x = a | ~b; y = a & b;  end
                4'd11: begin x = a & b;  y = 4'hF;   end
                4'd12: begin x = a;      y = a;      end
                4'd13: begin x = a | b;  y = a;      end
                4'd14: begin x = a | ~b; y = a;      end
                default: begin x = a;    y = 4'h0;   end
            endcase
            tot    = 5'(x) + 5'(y) + 5'(cin);
            it.res = tot[3:0];
            it.co  = tot[4];
            it.gp  = ((x ^ y) == 4'hF);
            it.gg  = ((5'(x) + 5'(y)) > 5'd15);
        end else begin
            case (s)
                4'd0:  it.res = ~a;
                4'd1:  it.res = ~(a | b);
                4'd2:  it.res = ~a & b;
                4'd3:  it.res = 4'h0;
                4'd4:  it.res = ~(a & b);
                4'd5:  it.res = ~b;
                4'd6:  it.res = a ^ b;
                4'd7:  it.res = a & ~b;
                4'd8:  it.res = ~a | b;
                4'd9:  it.res = ~(a ^ b);
                4'd10: it.res = b;
                4'd11: it.res = a & b;
                4'd12: it.res = a | ~b;
                4'd13: it.res = a | b;
                4'd14: it.res = a;
                default: it.res = 4'hF;
            endcase
            it.co = 1'b0; it.gp = 1'b0; it.gg = 1'b0;
        end
        return it;
    endfunction

    task automatic drive(input logic mode, input logic [3:0] s,
                         input logic [3:0] a, input logic [3:0] b,
                         input logic cin);
        @(posedge clk);
        logic_mode = mode; fn_sel = s; op_a = a; op_b = b; carry_in = cin;
        q.push_back(model(mode, s, a, b, cin));
    endtask

    // monitor: compares half a period after each drive
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            string rt;
            it = q.pop_front();
            if (!it.mode) begin
                if (it.cin)                 rt = "R3";
                else if (stated_code(it.sel)) rt = "R1";
                else                        rt = "R2";
                chk(rt, result, it.res);
                chk("R4 carry_out", carry_out, it.co);
                chk("R8 grp_prop", grp_prop, it.gp);
                chk("R8 grp_gen", grp_gen, it.gg);
                chk("R9 carry relation", carry_out,
                    int'(grp_gen | (grp_prop & it.cin)));
            end else begin
                if (it.cin)                 rt = "R7 cin ignored";
                else if (stated_code(it.sel)) rt = "R5";
                else                        rt = "R6";
                chk(rt, result, it.res);
                chk("R7 quiet carries", {carry_out, grp_prop, grp_gen}, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: all-zero inputs give code 0000 arithmetic on A=0
        chk("R1 reset state result", result, 0);
        chk("R4 reset state carry", carry_out, 0);
        // directed corners: full-width propagate with and without carry
        drive(1'b0, 4'd9, 4'h5, 4'hA, 1'b1);
        drive(1'b0, 4'd9, 4'h5, 4'hA, 1'b0);
        drive(1'b0, 4'd6, 4'h3, 4'h3, 1'b1);
        drive(1'b1, 4'd6, 4'hC, 4'hA, 1'b1);
        // exhaustive sweep of all 32 operations
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 16; s++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        for (int c = 0; c < 2; c++)
                            drive(m[0], s[3:0], a[3:0], b[3:0], c[0]);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule